// File: doc/BRIEF.md
# Type B Card Activation and Block Framing Sequencer

This block is the reader-side controller that brings a single proximity card of the Type B family into the active state and then carries data to it. On a select request it sends the fixed wake-up frame and waits for the card's answer. It keeps the card's four identifier bytes and the protocol-type nibble from that answer, builds the select frame from them, appends a CRC, and checks the length of the card's reply. On success the block-number bit is cleared.

After activation, every block request wraps a payload into an information frame: a control byte carrying the alternating block-number bit, a card-identifier byte of zero, the payload, and a CRC-B. The reply length is reported back. Transmit bytes leave through a valid/ready stream towards a bit serializer. Received bytes, a frame-done strobe and a byte count come in from a demodulator. A programmable response timeout guards every exchange. CRC checking of received frames and collision resolution are not done here.

Top module: `typeb_activation_seq`

## Requirements
- R1: A select request from a non-busy state first transmits the wake-up frame 0x05 0x00 0x08 0x39 0x73. The first byte is presented on the cycle after the request, and `tx_last` is high with the final byte.
- R2: If the wake-up answer is shorter than 14 bytes, the sequence ends with status fail (2'b11) and no select frame is sent.
- R3: The select frame is 11 bytes: 0x1D, answer bytes 1 to 4 in received order, 0x00, 0x08, then a byte with 0 in the upper nibble and the low nibble of answer byte 10, then 0x00, then two CRC bytes.
- R4: Each CRC field covers every earlier byte of its frame. It is computed with the reflected polynomial 0x8408, a start value of 0xFFFF and a final inversion, and is sent low byte first.
- R5: A select reply shorter than 3 bytes gives status fail and leaves the block-number bit unchanged. A reply of 3 bytes or more gives status success (2'b10) and clears the block-number bit to 0.
- R6: A block request from a non-busy state sends the control byte 0x0A OR the block-number bit, then 0x00, then `pay_len` payload bytes fetched by `pay_idx`, then the CRC. The block-number bit inverts after each block frame is sent.
- R7: When a block reply ends, the status becomes success. `resp_len` equals `rx_len` if that is 3 or more, and 0 otherwise.
- R8: If `rx_done` does not arrive within `timeout_cycles` cycles after the last transmitted byte, the exchange ends with status fail. For a block, `resp_len` is 0.
- R9: After reset the status is idle (2'b00) and `tx_valid` is low. While a sequence is running the status is busy (2'b01).
- R10: Select and block requests that arrive while busy are ignored: no extra frame is sent.
- R11: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| timeout_cycles | input | TMO_W | Response timeout in clock cycles |
| start_sel | input | 1 | Pulse: run wake-up and select |
| start_blk | input | 1 | Pulse: send one information block |
| pay_len | input | FRM_W | Payload length for a block, at most MAX_PAY |
| pay_idx | output | FRM_W | Index of the payload byte requested |
| pay_byte | input | 8 | Payload byte at `pay_idx` |
| tx_data | output | 8 | Byte to the serializer |
| tx_valid | output | 1 | `tx_data` is valid |
| tx_last | output | 1 | Current byte ends the frame |
| tx_ready | input | 1 | Serializer accepts the byte |
| rx_data | input | 8 | Received byte from the demodulator |
| rx_valid | input | 1 | `rx_data` is valid |
| rx_done | input | 1 | Received frame complete |
| rx_len | input | RXL_W | Byte count of the received frame |
| status | output | 2 | 00 idle, 01 busy, 10 success, 11 fail |
| resp_len | output | RXL_W | Reported length of the last block reply |

## Verification
The bound checker watches, on every cycle, the transmit handshake hold rule and that any byte on the wire coincides with busy status. It also checks that the first byte after an accepted select or block request is the wake-up or control byte, and that a reported reply length never falls in the range 1 to 2. The remaining behaviour can only be shown by scenarios. These are: copying the identifier and protocol nibble into the select frame; the CRC values; the pass and fail decisions on short wake-up and select replies; the block-number bit alternating and being cleared by a new selection; the timeout path; and requests that arrive while busy being dropped. The bench's scoreboard compares every transmitted byte and its last flag against frames predicted from these rules.

// File: rtl/typeb_seq_pkg.sv
package typeb_seq_pkg;

    typedef enum logic [1:0] {
        STAT_IDLE = 2'b00,
        STAT_BUSY = 2'b01,
        STAT_OK   = 2'b10,
        STAT_FAIL = 2'b11
    } seq_status_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WUP_TX,
        PH_WUP_RX,
        PH_SEL_TX,
        PH_SEL_RX,
        PH_BLK_TX,
        PH_BLK_RX
    } phase_e;

    localparam int WUP_LEN     = 5;
    localparam int SEL_LEN     = 11;
    localparam int SEL_CRC_POS = 9;
    localparam int ATQ_MIN     = 14;
    localparam int ANS_MIN     = 3;
    localparam logic [7:0] SEL_CODE = 8'h1D;
    localparam logic [7:0] PCB_BASE = 8'h0A;
    localparam logic [7:0] CID_BYTE = 8'h00;

    function automatic logic [7:0] wup_byte(input int unsigned pos);
        case (pos)
            0:       wup_byte = 8'h05;
            1:       wup_byte = 8'h00;
            2:       wup_byte = 8'h08;
            3:       wup_byte = 8'h39;
            default: wup_byte = 8'h73;
        endcase
    endfunction

    function automatic logic [15:0] crcb_step(input logic [15:0] cur, input logic [7:0] din);
        logic [15:0] c;
        c = cur ^ {8'h00, din};
        for (int k = 0; k < 8; k++) begin
            if (c[0]) c = (c >> 1) ^ 16'h8408;
            else      c = c >> 1;
        end
        crcb_step = c;
    endfunction

endpackage

// File: rtl/typeb_crc16.sv
module typeb_crc16
    import typeb_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       upd,
    input  logic [7:0] din,
    output logic [7:0] crc_lo,
    output logic [7:0] crc_hi
);
    logic [15:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (clr)      crc_d = 16'hFFFF;
        else if (upd) crc_d = crcb_step(crc_q, din);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= 16'hFFFF;
        else        crc_q <= crc_d;
    end

    assign crc_lo = ~crc_q[7:0];
    assign crc_hi = ~crc_q[15:8];
endmodule

// File: rtl/typeb_resp_timer.sv
module typeb_resp_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             run,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);
    logic [TMO_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (arm)                     cnt_d = '0;
        else if (run && !(&cnt_q))   cnt_d = cnt_q + TMO_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = run && (cnt_q >= limit);
endmodule

// File: rtl/typeb_atq_capture.sv
module typeb_atq_capture #(
    parameter int ID_BYTES  = 4,
    parameter int PROTO_POS = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  en,
    input  logic                  rx_valid,
    input  logic [7:0]            rx_data,
    output logic [8*ID_BYTES-1:0] card_id,
    output logic [3:0]            proto
);
    localparam int POS_W = $clog2(PROTO_POS + 2);

    typedef struct packed {
        logic [POS_W-1:0]      pos;
        logic [8*ID_BYTES-1:0] id;
        logic [3:0]            proto;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (clr) begin
            cap_d.pos = '0;
        end else if (en && rx_valid) begin
            for (int b = 0; b < ID_BYTES; b++) begin
                if (int'(cap_q.pos) == b + 1) cap_d.id[8*b +: 8] = rx_data;
            end
            if (int'(cap_q.pos) == PROTO_POS) cap_d.proto = rx_data[3:0];
            if (!(&cap_q.pos)) cap_d.pos = cap_q.pos + POS_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign card_id = cap_q.id;
    assign proto   = cap_q.proto;
endmodule

// File: rtl/typeb_activation_seq.sv
module typeb_activation_seq
    import typeb_seq_pkg::*;
#(
    parameter int MAX_PAY = 32,
    parameter int RXL_W   = 8,
    parameter int TMO_W   = 16,
    parameter int FRM_W   = $clog2(MAX_PAY + 5)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TMO_W-1:0] timeout_cycles,
    input  logic             start_sel,
    input  logic             start_blk,
    input  logic [FRM_W-1:0] pay_len,
    output logic [FRM_W-1:0] pay_idx,
    input  logic [7:0]       pay_byte,
    output logic [7:0]       tx_data,
    output logic             tx_valid,
    output logic             tx_last,
    input  logic             tx_ready,
    input  logic [7:0]       rx_data,
    input  logic             rx_valid,
    input  logic             rx_done,
    input  logic [RXL_W-1:0] rx_len,
    output logic [1:0]       status,
    output logic [RXL_W-1:0] resp_len
);
    localparam logic [FRM_W-1:0] MAX_PAY_F = FRM_W'(MAX_PAY);

    typedef struct packed {
        phase_e           phase;
        logic [FRM_W-1:0] idx;
        logic [FRM_W-1:0] plen;
        logic             bn;
        seq_status_e      stat;
        logic [RXL_W-1:0] rlen;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [FRM_W-1:0] frame_len;
    logic             at_last;
    logic             in_crc;
    logic             hs;
    logic [7:0]       crc_lo, crc_hi;
    logic [31:0]      card_id;
    logic [3:0]       proto;
    logic             tmo;
    logic             rx_phase;

    typeb_crc16 u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (!tx_valid),
        .upd    (hs && !in_crc),
        .din    (tx_data),
        .crc_lo (crc_lo),
        .crc_hi (crc_hi)
    );

    typeb_resp_timer #(.TMO_W(TMO_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (hs && at_last),
        .run     (rx_phase),
        .limit   (timeout_cycles),
        .expired (tmo)
    );

    typeb_atq_capture #(.ID_BYTES(4), .PROTO_POS(10)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (ctl_q.phase == PH_WUP_TX),
        .en       (ctl_q.phase == PH_WUP_RX),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .card_id  (card_id),
        .proto    (proto)
    );

    assign rx_phase = (ctl_q.phase == PH_WUP_RX) || (ctl_q.phase == PH_SEL_RX) ||
                      (ctl_q.phase == PH_BLK_RX);
    assign tx_valid = (ctl_q.phase == PH_WUP_TX) || (ctl_q.phase == PH_SEL_TX) ||
                      (ctl_q.phase == PH_BLK_TX);
    assign hs       = tx_valid && tx_ready;
    assign at_last  = (ctl_q.idx == frame_len - FRM_W'(1));
    assign tx_last  = tx_valid && at_last;
    assign pay_idx  = (ctl_q.phase == PH_BLK_TX) ? ctl_q.idx - FRM_W'(2) : '0;
    assign status   = ctl_q.stat;
    assign resp_len = ctl_q.rlen;

    // frame length, CRC window and byte multiplexer
    always_comb begin
        frame_len = '0;
        in_crc    = 1'b0;
        tx_data   = 8'h00;
        case (ctl_q.phase)
            PH_WUP_TX: begin
                frame_len = FRM_W'(WUP_LEN);
                tx_data   = wup_byte(int'(ctl_q.idx));
            end
            PH_SEL_TX: begin
                frame_len = FRM_W'(SEL_LEN);
                in_crc    = (ctl_q.idx >= FRM_W'(SEL_CRC_POS));
                case (int'(ctl_q.idx))
                    0:       tx_data = SEL_CODE;
                    1:       tx_data = card_id[7:0];
                    2:       tx_data = card_id[15:8];
                    3:       tx_data = card_id[23:16];
                    4:       tx_data = card_id[31:24];
                    6:       tx_data = 8'h08;
                    7:       tx_data = {4'h0, proto};
                    9:       tx_data = crc_lo;
                    10:      tx_data = crc_hi;
                    default: tx_data = 8'h00;
                endcase
            end
            PH_BLK_TX: begin
                frame_len = ctl_q.plen + FRM_W'(4);
                in_crc    = (ctl_q.idx >= ctl_q.plen + FRM_W'(2));
                if (ctl_q.idx == ctl_q.plen + FRM_W'(2))      tx_data = crc_lo;
                else if (ctl_q.idx == ctl_q.plen + FRM_W'(3)) tx_data = crc_hi;
                else if (ctl_q.idx == '0)                     tx_data = PCB_BASE | {7'h00, ctl_q.bn};
                else if (ctl_q.idx == FRM_W'(1))              tx_data = CID_BYTE;
                else                                          tx_data = pay_byte;
            end
            default: ;
        endcase
    end

    // next-state computation
    always_comb begin
        ctl_d = ctl_q;
        case (ctl_q.phase)
            PH_IDLE: begin
                if (start_sel) begin
                    ctl_d.phase = PH_WUP_TX;
                    ctl_d.idx   = '0;
                    ctl_d.stat  = STAT_BUSY;
                end else if (start_blk) begin
                    ctl_d.phase = PH_BLK_TX;
                    ctl_d.idx   = '0;
                    ctl_d.plen  = (pay_len > MAX_PAY_F) ? MAX_PAY_F : pay_len;
                    ctl_d.stat  = STAT_BUSY;
                    ctl_d.rlen  = '0;
                end
            end
            PH_WUP_TX, PH_SEL_TX, PH_BLK_TX: begin
                if (hs) begin
                    if (at_last) begin
                        ctl_d.idx = '0;
                        case (ctl_q.phase)
                            PH_WUP_TX: ctl_d.phase = PH_WUP_RX;
                            PH_SEL_TX: ctl_d.phase = PH_SEL_RX;
                            default: begin
                                ctl_d.phase = PH_BLK_RX;
                                ctl_d.bn    = ~ctl_q.bn;
                            end
                        endcase
                    end else begin
                        ctl_d.idx = ctl_q.idx + FRM_W'(1);
                    end
                end
            end
            PH_WUP_RX: begin
                if (rx_done) begin
                    if (rx_len < RXL_W'(ATQ_MIN)) begin
                        ctl_d.phase = PH_IDLE;
                        ctl_d.stat  = STAT_FAIL;
                    end else begin
                        ctl_d.phase = PH_SEL_TX;
                        ctl_d.idx   = '0;
                    end
                end else if (tmo) begin
                    ctl_d.phase = PH_IDLE;
                    ctl_d.stat  = STAT_FAIL;
                end
            end
            PH_SEL_RX: begin
                if (rx_done) begin
                    ctl_d.phase = PH_IDLE;
                    if (rx_len < RXL_W'(ANS_MIN)) begin
                        ctl_d.stat = STAT_FAIL;
                    end else begin
                        ctl_d.stat = STAT_OK;
                        ctl_d.bn   = 1'b0;
                    end
                end else if (tmo) begin
                    ctl_d.phase = PH_IDLE;
                    ctl_d.stat  = STAT_FAIL;
                end
            end
            PH_BLK_RX: begin
                if (rx_done) begin
                    ctl_d.phase = PH_IDLE;
                    ctl_d.stat  = STAT_OK;
                    ctl_d.rlen  = (rx_len < RXL_W'(ANS_MIN)) ? '0 : rx_len;
                end else if (tmo) begin
                    ctl_d.phase = PH_IDLE;
                    ctl_d.stat  = STAT_FAIL;
                    ctl_d.rlen  = '0;
                end
            end
            default: ctl_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.phase <= PH_IDLE;
            ctl_q.stat  <= STAT_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end
endmodule

// File: rtl/typeb_activation_chk.sv
module typeb_activation_chk #(
    parameter int RXL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_sel,
    input logic             start_blk,
    input logic [7:0]       tx_data,
    input logic             tx_valid,
    input logic             tx_ready,
    input logic [1:0]       status,
    input logic [RXL_W-1:0] resp_len
);
    assert_wup_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (status != 2'b01 && start_sel) |=> (tx_valid && tx_data == 8'h05));

    assert_pcb_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (status != 2'b01 && start_blk && !start_sel) |=> (tx_valid && tx_data[7:1] == 7'h05));

    assert_short_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_len == '0) || (resp_len >= RXL_W'(3)));

    assert_busy_tx_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (status == 2'b01));

    assert_tx_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
endmodule

bind typeb_activation_seq typeb_activation_chk #(.RXL_W(RXL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_sel (start_sel),
    .start_blk (start_blk),
    .tx_data   (tx_data),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .status    (status),
    .resp_len  (resp_len)
);

// File: tb/test_typeb_activation_seq.sv
module test_typeb_activation_seq;
    localparam int MAX_PAY = 32;
    localparam int RXL_W   = 8;
    localparam int TMO_W   = 16;
    localparam int FRM_W   = $clog2(MAX_PAY + 5);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [TMO_W-1:0] timeout_cycles = 16'd200;
    logic             start_sel = 1'b0;
    logic             start_blk = 1'b0;
    logic [FRM_W-1:0] pay_len = '0;
    logic [FRM_W-1:0] pay_idx;
    logic [7:0]       pay_byte;
    logic [7:0]       tx_data;
    logic             tx_valid;
    logic             tx_last;
    logic             tx_ready = 1'b0;
    logic [7:0]       rx_data = 8'h00;
    logic             rx_valid = 1'b0;
    logic             rx_done = 1'b0;
    logic [RXL_W-1:0] rx_len = '0;
    logic [1:0]       status;
    logic [RXL_W-1:0] resp_len;

    logic [7:0] pay_mem [0:MAX_PAY-1];
    assign pay_byte = pay_mem[pay_idx[4:0]];

    always #5 clk = ~clk;

    typeb_activation_seq #(.MAX_PAY(MAX_PAY), .RXL_W(RXL_W), .TMO_W(TMO_W)) i_typeb_activation_seq (
        .clk(clk), .rst_n(rst_n), .timeout_cycles(timeout_cycles),
        .start_sel(start_sel), .start_blk(start_blk), .pay_len(pay_len),
        .pay_idx(pay_idx), .pay_byte(pay_byte), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_last(tx_last), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_done(rx_done), .rx_len(rx_len),
        .status(status), .resp_len(resp_len)
    );

    int n_chk = 0;
    int n_fail = 0;
    int frames_seen = 0;
    int frames_exp = 0;
    logic [8:0] exp_q [$];
    logic [7:0] fb [$];
    logic [7:0] rq [$];
    logic exp_bn = 1'b0;

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_ref(input int n);
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < n; i++) begin
            c = c ^ {8'h00, fb[i]};
            for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
        end
        return ~c;
    endfunction

    // appends CRC (R4) when asked and pushes the frame into the scoreboard
    task automatic push_frame(input bit add_crc);
        logic [15:0] c;
        if (add_crc) begin
            c = crc_ref(fb.size());
            fb.push_back(c[7:0]);
            fb.push_back(c[15:8]);
        end
        foreach (fb[i]) exp_q.push_back({(i == fb.size() - 1), fb[i]});
        frames_exp++;
        fb.delete();
    endtask

    // monitor: serializer model with back-pressure, pops and compares
    int rdy_cnt = 0;
    always @(negedge clk) begin
        logic [8:0] e;
        if (rst_n) begin
            rdy_cnt++;
            tx_ready = (rdy_cnt % 4) != 3;
            if (tx_valid && tx_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R10 unexpected tx byte", int'(tx_data), 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(tx_data == e[7:0], "R1/R3/R4/R6 tx byte", int'(tx_data), int'(e[7:0]));
                    chk(tx_last == e[8], "R1 tx_last flag", int'(tx_last), int'(e[8]));
                end
                if (tx_last) frames_seen++;
            end
        end
    end

    task automatic wait_frame();
        while (frames_seen < frames_exp) @(posedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic reply(input int n);
        for (int i = 0; i < n; i++) begin
            rx_valid = 1'b1;
            rx_data  = (i < rq.size()) ? rq[i] : 8'hEE;
            @(negedge clk);
        end
        rx_valid = 1'b0;
        rx_done  = 1'b1;
        rx_len   = RXL_W'(n);
        @(negedge clk);
        rx_done  = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_sel();
        start_sel = 1'b1;
        @(negedge clk);
        start_sel = 1'b0;
        chk(status == 2'b01, "R9 busy after select request", int'(status), 1);
    endtask

    task automatic pulse_blk(input int n);
        pay_len = FRM_W'(n);
        start_blk = 1'b1;
        @(negedge clk);
        start_blk = 1'b0;
        chk(status == 2'b01, "R9 busy after block request", int'(status), 1);
    endtask

    task automatic push_wup();
        fb = '{8'h05, 8'h00, 8'h08, 8'h39, 8'h73};
        push_frame(1'b0);
    endtask

    task automatic load_atq(input logic [7:0] b10);
        rq = '{8'h50, 8'hA1, 8'hB2, 8'hC3, 8'hD4, 8'h20, 8'h38, 8'h19, 8'h22, 8'h00,
               b10, 8'h85, 8'h5E, 8'hD7};
    endtask

    // full activation with a select answer of ans_n bytes; R3 frame is predicted
    task automatic do_select(input logic [7:0] b10, input int ans_n);
        push_wup();
        pulse_sel();
        wait_frame();
        fb = '{8'h1D, 8'hA1, 8'hB2, 8'hC3, 8'hD4, 8'h00, 8'h08, {4'h0, b10[3:0]}, 8'h00};
        push_frame(1'b1);
        load_atq(b10);
        reply(14);
        wait_frame();
        chk(status == 2'b01, "R9 busy awaiting select answer", int'(status), 1);
        rq = '{8'h00, 8'h78, 8'hF0, 8'h11};
        reply(ans_n);
        if (ans_n < 3) begin
            chk(status == 2'b11, "R5 short select answer fails", int'(status), 3);
        end else begin
            chk(status == 2'b10, "R5 select success", int'(status), 2);
            exp_bn = 1'b0;
        end
    endtask

    task automatic do_block(input int n);
        fb.delete();
        fb.push_back(8'h0A | {7'h00, exp_bn});
        fb.push_back(8'h00);
        for (int i = 0; i < n; i++) fb.push_back(pay_mem[i]);
        push_frame(1'b1);
        pulse_blk(n);
        exp_bn = ~exp_bn;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < MAX_PAY; i++) pay_mem[i] = 8'(8'h30 + 8'(i * 7));
        repeat (4) @(negedge clk);
        chk(status == 2'b00, "R9 idle after reset", int'(status), 0);
        chk(tx_valid == 1'b0, "R9 no tx after reset", int'(tx_valid), 0);
        chk(resp_len == '0, "R7 resp_len reset", int'(resp_len), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(status == 2'b00, "R9 idle after release", int'(status), 0);

        // R1, R2: wake-up answer of 13 bytes
        push_wup();
        pulse_sel();
        wait_frame();
        load_atq(8'h21);
        reply(13);
        chk(status == 2'b11, "R2 short wake-up answer fails", int'(status), 3);
        repeat (30) @(negedge clk);
        chk(exp_q.size() == 0, "R2 no select after short answer", exp_q.size(), 0);

        // R3, R4, R5: activation with protocol nibble 7 from byte 0xE7
        do_select(8'hE7, 3);

        // R6, R7, R10: block with 3 bytes, control 0x0A, select request while busy
        do_block(3);
        start_sel = 1'b1;
        @(negedge clk);
        start_sel = 1'b0;
        start_blk = 1'b1;
        @(negedge clk);
        start_blk = 1'b0;
        wait_frame();
        chk(status == 2'b01, "R9 busy awaiting block reply", int'(status), 1);
        rq = '{8'h02, 8'h90, 8'h00, 8'h12, 8'h34};
        reply(5);
        chk(status == 2'b10, "R7 block reply success", int'(status), 2);
        chk(resp_len == 8'd5, "R7 reply length reported", int'(resp_len), 5);
        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0 && frames_seen == frames_exp, "R10 requests while busy ignored",
            frames_seen, frames_exp);

        // R6, R7: empty payload, control 0x0B, reply of 2 bytes reported as 0
        do_block(0);
        wait_frame();
        rq = '{8'h0B, 8'h00};
        reply(2);
        chk(status == 2'b10, "R7 short block reply status", int'(status), 2);
        chk(resp_len == 8'd0, "R7 short block reply length", int'(resp_len), 0);

        // R8: no reply within 20 cycles
        timeout_cycles = 16'd20;
        do_block(5);
        wait_frame();
        repeat (15) @(negedge clk);
        chk(status == 2'b01, "R8 still busy before timeout", int'(status), 1);
        repeat (30) @(negedge clk);
        chk(status == 2'b11, "R8 timeout fails", int'(status), 3);
        chk(resp_len == 8'd0, "R8 timeout length zero", int'(resp_len), 0);
        timeout_cycles = 16'd200;

        // R5: short select answer keeps the block bit (now 1), then success clears it
        do_select(8'h5C, 2);
        do_block(1);
        wait_frame();
        rq = '{8'h0B, 8'h00, 8'h00};
        reply(3);
        chk(resp_len == 8'd3, "R7 reply length 3", int'(resp_len), 3);
        do_block(2);
        wait_frame();
        reply(4);
        do_select(8'hF3, 4);
        do_block(MAX_PAY);
        wait_frame();
        rq = '{8'h02, 8'h00, 8'h00, 8'h00};
        reply(4);
        chk(status == 2'b10 && resp_len == 8'd4, "R6 long block after reselect",
            int'(resp_len), 4);
        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule